// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is an 8-bit serial peripheral port that can run as the bus master or as a selected slave. One control bit picks the role. In master role the port generates the shift clock from the system clock, drives the clock and outgoing data pins, and samples the incoming data pin. In slave role the shift clock and the select line come in from outside. The port then drives its outgoing data pin only while it is selected.

Software uses a small register bus with three addresses: control, status and data. A byte written to the data address is staged in a write buffer and then moved into the single 8-bit shift register. When a byte completes, the shifted-in value is copied to a separate read buffer, and a done flag is raised together with an interrupt request. Because of the write buffer, a master can run bytes back to back without a gap.

The incoming clock, select and data pins are passed through two-flop synchronizers, and edges are found on the synchronized levels. For this reason, an external slave clock may run at no more than one quarter of the system clock.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, `irq` is low, `sck_o` is low and all three output enables are low.
- R2: The control register (address 0) holds bit 0 enable, bit 1 master role and bits 3:2 clock select. With enable and master both set, `sck_oe` and `mosi_oe` are high and `miso_oe` is low. The two data-pin enables are never high together.
- R3: In master role the shift clock period is 4, 8, 32 or 64 system clocks for clock select 0, 1, 2 or 3.
- R4: In master role, a byte written to the data register (address 2) while idle is shifted out MSB first. `sck_o` idles low, `mosi_o` changes only on falling SCK edges, and `miso_i` is sampled on rising edges. After 8 bits the received byte is readable at the data address.
- R5: A data write made during a master transfer is held and starts the next byte directly after the current one, with no lengthened SCK period between the two bytes.
- R6: In master role the select input `ss_n_i` has no effect: transfers run while it is held high.
- R7: In slave role with enable set, `miso_oe` is high only while `ss_n_i` is low. While selected, the external SCK shifts the preloaded byte out on `miso_o` MSB first, and the byte received on `mosi_i` goes to the read buffer.
- R8: In slave role, a rising `ss_n_i` before 8 bits have arrived drops the partial byte and sets no done flag. It leaves the read buffer unchanged and restarts the bit count, so the next selection receives a full byte.
- R9: Completion sets status bit 7 and `irq`. Both clear only after a status read followed by a data read; a data read alone leaves them set.
- R10: With enable clear, the port drives no pin, keeps `sck_o` low, and ignores data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_rd | input | 1 | Read qualifier for the access (read side effects) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Transfer-complete interrupt request |
| sck_i | input | 1 | Shift clock input (slave role) |
| sck_o | output | 1 | Shift clock output (master role) |
| sck_oe | output | 1 | Shift clock output enable |
| mosi_i | input | 1 | Master-out data input (slave role) |
| mosi_o | output | 1 | Master-out data output (master role) |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in data input (master role) |
| miso_o | output | 1 | Master-in data output (slave role) |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench measures the SCK period at each of the four clock selects. A divider with a wrong ratio shows up directly as a period mismatch. It also queues a second byte while the first is on the wire and checks that no rising-edge gap between the bytes is longer than one period; a port that dropped or delayed the buffered byte would fail that check or send the wrong sequence. A slave selection is broken off after three bits, and the following full byte is then checked. A port that kept the stale bit count would finish early and post a corrupted value, and one that updated the read buffer on abort would expose the partial byte. The flag-clearing order is tested by reading data without a status read first, which must leave the interrupt set.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CNT_W   = $clog2(BYTE_W);
    localparam int unsigned HALF_W  = 6;
    localparam int unsigned DONE_BIT = 7;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_addr_e;

    // bits [3:2] clock select, [1] master role, [0] enable
    typedef struct packed {
        logic [1:0] div_sel;
        logic       master;
        logic       en;
    } ctrl_t;

    // half of the SCK period, in system clocks
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] sel);
        case (sel)
            2'd0:    half_period = HALF_W'(2);
            2'd1:    half_period = HALF_W'(4);
            2'd2:    half_period = HALF_W'(16);
            default: half_period = HALF_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= din[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int unsigned HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;
    logic              at_end;

    assign at_end = (cnt == half - HALF_W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run || at_end) cnt <= '0;
        else                       cnt <= cnt + HALF_W'(1);
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              sample_en,
    input  logic              sample_bit,
    input  logic              shift_en,
    output logic              sout,
    output logic [CNT_W-1:0]  bitcnt,
    output logic              last,
    output logic [BYTE_W-1:0] next_byte
);
    logic [BYTE_W-1:0] sreg;
    logic              samp;

    assign sout      = sreg[BYTE_W-1];
    assign next_byte = {sreg[BYTE_W-2:0], samp};
    assign last      = shift_en && (bitcnt == CNT_W'(BYTE_W-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '0;
            samp   <= 1'b0;
            bitcnt <= '0;
        end else begin
            if (sample_en) samp <= sample_bit;
            if (clear) begin
                bitcnt <= '0;
            end else if (shift_en) begin
                sreg   <= next_byte;
                bitcnt <= bitcnt + CNT_W'(1);
            end
            if (load) sreg <= load_data;
        end
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       ss_n_i
);
    ctrl_t             ctrl;
    logic              ctrl_en, ctrl_master;
    logic [BYTE_W-1:0] wbuf, rbuf;
    logic              pend, flag, armed, active, sck_r;

    // synchronized pins: {mosi, ss, sck}
    logic [2:0] pin_q;
    logic       sck_q, ss_q, mosi_q, sck_d, ss_d;

    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst), .din({mosi_i, ss_n_i, sck_i}), .q(pin_q)
    );
    assign {mosi_q, ss_q, sck_q} = pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= sck_q;
            ss_d  <= ss_q;
        end
    end

    assign ctrl_en     = ctrl.en;
    assign ctrl_master = ctrl.master;

    logic slave_on, ss_abort, tick;
    assign slave_on = ctrl_en && !ctrl_master && !ss_q;
    assign ss_abort = !ctrl_master && ss_q && !ss_d;

    spi_clkgen #(.HALF_W(HALF_W)) u_clkgen (
        .clk(clk), .rst(rst), .run(active),
        .half(half_period(ctrl.div_sel)), .tick(tick)
    );

    logic             sample_en, shift_en, load, last, sout, busy;
    logic [CNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0] next_byte;

    always_comb begin
        if (ctrl_master) begin
            sample_en = active && tick && !sck_r;
            shift_en  = active && tick && sck_r;
        end else begin
            sample_en = slave_on && sck_q && !sck_d;
            shift_en  = slave_on && !sck_q && sck_d;
        end
    end

    assign busy = active || (bitcnt != '0);
    assign load = ctrl_en && pend && (!busy || last);

    spi_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst(rst),
        .clear(!ctrl_en || ss_abort),
        .load(load), .load_data(wbuf),
        .sample_en(sample_en),
        .sample_bit(ctrl_master ? miso_i : mosi_q),
        .shift_en(shift_en),
        .sout(sout), .bitcnt(bitcnt), .last(last), .next_byte(next_byte)
    );

    logic wr_ctrl, wr_data, rd_stat, rd_data;
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    assign wr_data = bus_sel && bus_wr && (bus_addr == REG_DATA);
    assign rd_stat = bus_sel && bus_rd && (bus_addr == REG_STAT);
    assign rd_data = bus_sel && bus_rd && (bus_addr == REG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            wbuf   <= '0;
            pend   <= 1'b0;
            active <= 1'b0;
            sck_r  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[3:0]);
            if (!ctrl_en) begin
                pend   <= 1'b0;
                active <= 1'b0;
                sck_r  <= 1'b0;
            end else begin
                if (load)    pend <= 1'b0;
                if (wr_data) begin
                    wbuf <= bus_wdata;
                    pend <= 1'b1;
                end
                if (!ctrl_master) begin
                    active <= 1'b0;
                    sck_r  <= 1'b0;
                end else begin
                    if (active && tick) sck_r <= !sck_r;
                    if (load)           active <= 1'b1;
                    else if (last)      active <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf  <= '0;
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (last) begin
            rbuf  <= next_byte;
            flag  <= 1'b1;
            armed <= 1'b0;
        end else begin
            if (rd_stat && flag) armed <= 1'b1;
            if (rd_data && armed) begin
                flag  <= 1'b0;
                armed <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = {4'b0, ctrl};
            REG_STAT: bus_rdata = 8'(flag) << DONE_BIT;
            REG_DATA: bus_rdata = rbuf;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = flag;
    assign sck_o   = sck_r;
    assign sck_oe  = ctrl_en && ctrl_master;
    assign mosi_o  = sout;
    assign mosi_oe = ctrl_en && ctrl_master;
    assign miso_o  = sout;
    assign miso_oe = ctrl_en && !ctrl_master && !ss_n_i;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_en,
    input logic       ctrl_master,
    input logic       active,
    input logic [2:0] bitcnt,
    input logic       sck_o,
    input logic       mosi_o,
    input logic       irq,
    input logic       miso_oe,
    input logic       mosi_oe
);
    AST_ONE_DATA_DRIVER: assert property (@(posedge clk) disable iff (rst)
        !(miso_oe && mosi_oe)); // R2

    AST_MOSI_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (active && sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R4

    AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sck_o); // R4

    AST_IRQ_AFTER_FULL_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(bitcnt) == 3'd7)); // R8

    AST_SCK_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_en && ctrl_master) |=> !sck_o); // R10
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_master(ctrl_master),
    .active(active), .bitcnt(bitcnt), .sck_o(sck_o), .mosi_o(mosi_o),
    .irq(irq), .miso_oe(miso_oe), .mosi_oe(mosi_oe)
);

// File: tb/test_spi_port.sv
module test_spi_port;
    localparam int CLK_P = 10;

    logic       clk = 1'b0, rst = 1'b1;
    logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 0, mosi_i = 0, ss_n_i = 1;
    logic [7:0] tb_tx = 0;
    wire        miso_i = tb_tx[7];

    int n_cmp = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
        .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard: expected master-out bytes
    logic [7:0] exp_q[$];
    logic [7:0] mon_sh = 0;
    int         mon_n = 0, mon_rises = 0;
    time        mon_last = 0, mon_gap = 0;

    // bench-side slave: rotate so the same byte repeats
    always @(negedge sck_o) tb_tx <= {tb_tx[6:0], tb_tx[7]};

    always @(posedge sck_o) begin
        mon_rises++;
        if (mon_last != 0 && ($time - mon_last) > mon_gap) mon_gap = $time - mon_last;
        mon_last = $time;
        mon_sh = {mon_sh[6:0], mosi_o};
        mon_n++;
        if (mon_n == 8) begin
            mon_n = 0;
            if (exp_q.size() == 0) check("R4 unexpected byte", mon_sh, -1);
            else check("R4 mosi byte", mon_sh, exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        check(req, irq, 1);
    endtask

    task automatic measure_sck(output int cyc);
        time t0;
        @(posedge sck_o); t0 = $time;
        @(posedge sck_o); cyc = int'(($time - t0) / CLK_P);
    endtask

    task automatic slave_xfer(input logic [7:0] mo, input int nbits, output logic [7:0] got);
        got = 0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi_i = mo[i];
            repeat (8) @(negedge clk);
            sck_i = 1;
            got = {got[6:0], miso_o};
            repeat (8) @(negedge clk);
            sck_i = 0;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd, got;
        int cyc;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); check("R1 ctrl", rd, 8'h00);
        bus_read(2'd1, rd); check("R1 status", rd, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 sck_o", sck_o, 0);
        check("R1 enables", {sck_oe, mosi_oe, miso_oe}, 3'b000);

        // R2 master directions, ss held high throughout (R6)
        ss_n_i = 1;
        bus_write(2'd0, 8'h03);
        check("R2 master enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);

        // R3/R4/R9 all four clock selects
        for (int s = 0; s < 4; s++) begin
            logic [7:0] mo, mi;
            mo = 8'hC3 ^ 8'(s * 37);
            mi = 8'h5A + 8'(s * 19);
            tb_tx = mi;
            bus_write(2'd0, 8'({s[1:0], 2'b11}));
            exp_q.push_back(mo);
            bus_write(2'd2, mo);
            measure_sck(cyc);
            check("R3 sck period", cyc, 4 << (s == 0 ? 0 : s == 1 ? 1 : s == 2 ? 3 : 4));
            wait_irq(s == 0 ? "R6 transfer with ss high" : "R4 completion irq");
            if (s == 0) begin
                bus_read(2'd2, rd);
                check("R9 data read alone keeps irq", irq, 1);
            end
            bus_read(2'd1, rd); check("R9 status done bit", rd, 8'h80);
            bus_read(2'd2, rd); check("R4 received byte", rd, mi);
            check("R9 irq cleared", irq, 0);
        end

        // R5 back-to-back bytes
        bus_write(2'd0, 8'h03);
        tb_tx = 8'hA5;
        mon_last = 0; mon_gap = 0;
        exp_q.push_back(8'h11); exp_q.push_back(8'h22);
        bus_write(2'd2, 8'h11);
        repeat (3) @(negedge clk);
        bus_write(2'd2, 8'h22);
        repeat (100) @(negedge clk);
        check("R5 no gap between bytes", int'(mon_gap / CLK_P), 4);
        check("R5 both bytes sent", exp_q.size(), 0);
        bus_read(2'd1, rd); bus_read(2'd2, rd);
        check("R5 second byte received", rd, 8'hA5);

        // R10 disabled port
        bus_write(2'd0, 8'h02);
        cyc = mon_rises;
        bus_write(2'd2, 8'h77);
        repeat (60) @(negedge clk);
        check("R10 no sck edges", mon_rises, cyc);
        check("R10 no drive", {sck_oe, mosi_oe, miso_oe, sck_o}, 4'b0000);
        check("R10 no irq", irq, 0);

        // R7 slave transfer
        bus_write(2'd0, 8'h01);
        ss_n_i = 1;
        @(negedge clk);
        check("R7 miso released while deselected", miso_oe, 0);
        bus_write(2'd2, 8'h96);
        repeat (4) @(negedge clk);
        ss_n_i = 0;
        repeat (6) @(negedge clk);
        check("R7 miso driven while selected", {miso_oe, sck_oe, mosi_oe}, 3'b100);
        slave_xfer(8'h4B, 8, got);
        check("R7 slave sent preload", got, 8'h96);
        check("R7 slave irq", irq, 1);
        bus_read(2'd1, rd); bus_read(2'd2, rd);
        check("R7 slave received", rd, 8'h4B);
        ss_n_i = 1;
        repeat (6) @(negedge clk);

        // R8 abort after three bits
        ss_n_i = 0;
        repeat (6) @(negedge clk);
        slave_xfer(8'hE1, 3, got);
        ss_n_i = 1;
        repeat (10) @(negedge clk);
        check("R8 no irq on abort", irq, 0);
        check("R8 miso released", miso_oe, 0);
        bus_read(2'd2, rd); check("R8 read buffer kept", rd, 8'h4B);
        bus_write(2'd2, 8'hC7);
        repeat (4) @(negedge clk);
        ss_n_i = 0;
        repeat (6) @(negedge clk);
        slave_xfer(8'h3E, 7, got);
        check("R8 no early completion", irq, 0);
        mosi_i = 1'b0;
        repeat (8) @(negedge clk); sck_i = 1;
        got = {got[6:0], miso_o};
        repeat (8) @(negedge clk); sck_i = 0;
        repeat (6) @(negedge clk);
        check("R8 full byte after abort", irq, 1);
        check("R8 sent after abort", got, 8'hC7);
        bus_read(2'd1, rd); bus_read(2'd2, rd);
        check("R8 received after abort", rd, 8'h3E);
        ss_n_i = 1;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule